// File: doc/BRIEF.md
# Extended-Precision Float Compare Unit

This unit orders two 80-bit extended-precision operands, each laid out as `{sign, 15-bit biased exponent, 64-bit significand}` with the sign in bit 79 and an explicit integer bit at significand bit 63. It classifies each operand (zero, normal, denormal, pseudo-denormal, infinity, quiet NaN, signalling NaN, unsupported encoding), brings denormals to normalized form, and then decides equal, less-than, greater-than or unordered. The result is written into a 16-bit status word as condition and exception bits, and is also mirrored onto three integer-style flags (zero, parity, carry) for the flag-setting variant of the compare.

A request is presented with a one-cycle `in_valid` strobe. The operands, the mode bits, the two exception masks and the incoming status word are registered on that edge, and the result is valid during the following cycle, marked by a one-cycle `done` pulse. `quiet_mode` selects the quiet compare, in which only a signalling NaN raises the invalid exception; otherwise any NaN does. `flag_mode` selects the flag-setting compare, in which the condition bits of the status word keep their incoming values.

Top module: `xfp_compare_unit`

## Requirements
- R1: `done` is high for exactly the one cycle after each cycle in which `in_valid` is sampled high, and is low otherwise, including right after reset.
- R2: An unsupported encoding in either operand (exponent all ones with bit 63 clear, or exponent neither zero nor all ones with bit 63 clear) yields C0, C2, C3 and IE set, DE clear, and ES and B set exactly when `inv_mask` is 0; no ordering is performed.
- R3: Otherwise a NaN in either operand (exponent all ones, bit 63 set, bits 62..0 nonzero) yields C0, C2 and C3 all set with DE clear, even when the other operand is denormal.
- R4: In that unordered case IE is set when `quiet_mode` is 0, or when either operand is a signalling NaN (bit 62 clear); a quiet NaN (bit 62 set) in quiet mode leaves IE clear. ES and B are set exactly when IE is set and `inv_mask` is 0.
- R5: A denormal (exponent 0, bit 63 clear, nonzero significand) is compared by its true value after left-normalization, its exponent becoming 1 minus the shift count.
- R6: A pseudo-denormal (exponent 0, bit 63 set) is compared as exponent 1 with its significand unchanged.
- R7: For ordered compares, DE is set when either operand is denormal or pseudo-denormal, and ES and B are set exactly when DE is set and `den_mask` is 0; with no such operand DE, ES and B are clear.
- R8: Equal values set C3 only; +0 and -0 compare equal.
- R9: A negative first operand against a positive second operand (not both zero) sets C0 only.
- R10: With equal signs and exactly one zero operand, C0 is set for a zero first operand only when both are positive, and for a zero second operand only when both are negative.
- R11: Otherwise, with equal signs, C0 is set when the first operand is smaller in value (taking the sign into account); a greater first operand sets no condition bit.
- R12: `flag_zf`, `flag_pf` and `flag_cf` equal the computed C3, C2 and C0 in both modes; with `flag_mode` 1 the status condition bits C0, C1, C2, C3 equal those of `status_in`, and with `flag_mode` 0 they take the result with C1 cleared.
- R13: Status bit positions are IE 0, DE 1, ES 7, C0 8, C1 9, C2 10, C3 14, B 15; all other bits of `status_out` equal `status_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; captures all inputs |
| op_a | input | 80 | First operand `{sign, exponent, significand}` |
| op_b | input | 80 | Second operand, same layout |
| quiet_mode | input | 1 | 1: invalid only on signalling NaN; 0: invalid on any NaN |
| flag_mode | input | 1 | 1: keep incoming condition bits, result on flags |
| inv_mask | input | 1 | Invalid-operation mask |
| den_mask | input | 1 | Denormal-operand mask |
| status_in | input | 16 | Incoming status word |
| done | output | 1 | Result valid pulse |
| status_out | output | 16 | Updated status word |
| flag_zf | output | 1 | Equal / unordered flag (C3) |
| flag_pf | output | 1 | Unordered flag (C2) |
| flag_cf | output | 1 | Less-than / unordered flag (C0) |

## Verification
A misclassified operand shows at the ports in the same result cycle as a wrong unordered or invalid pattern, for example a quiet NaN raising IE in quiet mode or an unnormal being ordered instead of rejected. A wrong normalization shift hides behind most inputs and only appears as a flipped C0 or a lost C3 when two denormals of near magnitude, or a denormal and the smallest normal, are compared, so the stimulus deliberately places operands at those boundaries. Because every state register is recaptured on each request, a corrupted register affects only the one result that follows it.

// File: rtl/xcmp_pkg.sv
package xcmp_pkg;

  typedef enum logic [2:0] {
    K_ZERO, K_NORMAL, K_DENORM, K_PSEUDO_DEN,
    K_INF, K_QNAN, K_SNAN, K_UNSUP
  } opkind_e;

  localparam int ST_IE = 0;
  localparam int ST_DE = 1;
  localparam int ST_ES = 7;
  localparam int ST_C0 = 8;
  localparam int ST_C1 = 9;
  localparam int ST_C2 = 10;
  localparam int ST_C3 = 14;
  localparam int ST_B  = 15;

endpackage

// File: rtl/xcmp_operand.sv
module xcmp_operand
  import xcmp_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MAN_W  = 64,
  parameter int NEXP_W = EXP_W + 2
) (
  input  logic [EXP_W-1:0]         exp_in,
  input  logic [MAN_W-1:0]         man_in,
  output opkind_e                  kind,
  output logic                     is_zero,
  output logic signed [NEXP_W-1:0] norm_exp,
  output logic [MAN_W-1:0]         norm_man
);
  localparam int LZ_W = $clog2(MAN_W) + 1;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [MAN_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic hit;
    n   = '0;
    hit = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + LZ_W'(1);
    end
    return n;
  endfunction

  logic            exp_max, exp_min, int_bit;
  logic [LZ_W-1:0] shift;

  assign exp_max = &exp_in;
  assign exp_min = ~|exp_in;
  assign int_bit = man_in[MAN_W-1];
  assign shift   = lead_zeros(man_in);

  always_comb begin
    if (exp_max) begin
      if (!int_bit)                    kind = K_UNSUP;
      else if (~|man_in[MAN_W-2:0])    kind = K_INF;
      else if (man_in[MAN_W-2])        kind = K_QNAN;
      else                             kind = K_SNAN;
    end else if (exp_min) begin
      if (~|man_in)                    kind = K_ZERO;
      else if (int_bit)                kind = K_PSEUDO_DEN;
      else                             kind = K_DENORM;
    end else begin
      kind = int_bit ? K_NORMAL : K_UNSUP;
    end
  end

  assign is_zero = (kind == K_ZERO);

  always_comb begin
    norm_exp = NEXP_W'(exp_in);
    norm_man = man_in;
    if (kind == K_DENORM) begin
      norm_man = man_in << shift;
      norm_exp = NEXP_W'(1) - NEXP_W'(shift);
    end else if (kind == K_PSEUDO_DEN) begin
      norm_exp = NEXP_W'(1);
    end
  end

  always_comb begin
    if (kind == K_DENORM)
      assert_denorm_top_bit_R5: assert (norm_man[MAN_W-1] && norm_exp <= 0)
        else $error("denormal left unnormalized");
  end

endmodule

// File: rtl/xcmp_order.sv
module xcmp_order #(
  parameter int MAN_W  = 64,
  parameter int NEXP_W = 17
) (
  input  logic                     sign_a,
  input  logic                     zero_a,
  input  logic signed [NEXP_W-1:0] exp_a,
  input  logic [MAN_W-1:0]         man_a,
  input  logic                     sign_b,
  input  logic                     zero_b,
  input  logic signed [NEXP_W-1:0] exp_b,
  input  logic [MAN_W-1:0]         man_b,
  output logic                     is_eq,
  output logic                     is_lt
);
  logic same_mag, mag_lt;

  assign same_mag = (man_a == man_b) && (exp_a == exp_b);
  assign mag_lt   = (exp_a < exp_b) || ((exp_a == exp_b) && (man_a < man_b));
  assign is_eq    = same_mag && ((sign_a == sign_b) || (zero_a && zero_b));

  always_comb begin
    is_lt = 1'b0;
    if (!is_eq) begin
      if (sign_a && !sign_b)     is_lt = 1'b1;
      else if (sign_a == sign_b) begin
        if (zero_a)              is_lt = !sign_a;
        else if (zero_b)         is_lt = sign_a;
        else                     is_lt = sign_a ^ mag_lt;
      end
    end
  end

  always_comb begin
    assert_eq_lt_exclusive_R11: assert (!(is_eq && is_lt))
      else $error("equal and less both reported");
  end

endmodule

// File: rtl/xfp_compare_unit.sv
module xfp_compare_unit
  import xcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  parameter int SW_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [EXP_W+MAN_W:0]         op_a,
  input  logic [EXP_W+MAN_W:0]         op_b,
  input  logic                         quiet_mode,
  input  logic                         flag_mode,
  input  logic                         inv_mask,
  input  logic                         den_mask,
  input  logic [SW_W-1:0]              status_in,
  output logic                         done,
  output logic [SW_W-1:0]              status_out,
  output logic                         flag_zf,
  output logic                         flag_pf,
  output logic                         flag_cf
);
  localparam int OP_W   = EXP_W + MAN_W + 1;
  localparam int NEXP_W = EXP_W + 2;

  logic [OP_W-1:0] op_q [2];
  logic            quiet_q, flag_q, im_q, dm_q, done_q;
  logic [SW_W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q[0] <= '0;
      op_q[1] <= '0;
      quiet_q <= 1'b0;
      flag_q  <= 1'b0;
      im_q    <= 1'b1;
      dm_q    <= 1'b1;
      st_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= in_valid;
      if (in_valid) begin
        op_q[0] <= op_a;
        op_q[1] <= op_b;
        quiet_q <= quiet_mode;
        flag_q  <= flag_mode;
        im_q    <= inv_mask;
        dm_q    <= den_mask;
        st_q    <= status_in;
      end
    end
  end

  opkind_e                  kind    [2];
  logic                     zero_v  [2];
  logic signed [NEXP_W-1:0] nexp    [2];
  logic [MAN_W-1:0]         nman    [2];

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    xcmp_operand #(.EXP_W(EXP_W), .MAN_W(MAN_W), .NEXP_W(NEXP_W)) u_opnd (
      .exp_in   (op_q[g][MAN_W +: EXP_W]),
      .man_in   (op_q[g][MAN_W-1:0]),
      .kind     (kind[g]),
      .is_zero  (zero_v[g]),
      .norm_exp (nexp[g]),
      .norm_man (nman[g])
    );
  end

  logic ord_eq, ord_lt;

  xcmp_order #(.MAN_W(MAN_W), .NEXP_W(NEXP_W)) u_order (
    .sign_a (op_q[0][OP_W-1]), .zero_a (zero_v[0]),
    .exp_a  (nexp[0]),         .man_a  (nman[0]),
    .sign_b (op_q[1][OP_W-1]), .zero_b (zero_v[1]),
    .exp_b  (nexp[1]),         .man_b  (nman[1]),
    .is_eq  (ord_eq),
    .is_lt  (ord_lt)
  );

  // Named events shared by the result logic and the assertions.
  logic any_unsup, any_nan, any_snan, any_den;
  assign any_unsup = (kind[0] == K_UNSUP) || (kind[1] == K_UNSUP);
  assign any_snan  = (kind[0] == K_SNAN)  || (kind[1] == K_SNAN);
  assign any_nan   = any_snan || (kind[0] == K_QNAN) || (kind[1] == K_QNAN);
  assign any_den   = (kind[0] == K_DENORM) || (kind[0] == K_PSEUDO_DEN)
                  || (kind[1] == K_DENORM) || (kind[1] == K_PSEUDO_DEN);

  logic c0, c2, c3, ie, de, es;

  always_comb begin
    {c0, c2, c3, ie, de, es} = '0;
    if (any_unsup) begin
      {c0, c2, c3, ie} = 4'b1111;
      es = !im_q;
    end else if (any_nan) begin
      {c0, c2, c3} = 3'b111;
      ie = !quiet_q || any_snan;
      es = ie && !im_q;
    end else begin
      c3 = ord_eq;
      c0 = ord_lt;
      de = any_den;
      es = any_den && !dm_q;
    end
  end

  always_comb begin
    status_out        = st_q;
    status_out[ST_IE] = ie;
    status_out[ST_DE] = de;
    status_out[ST_ES] = es;
    status_out[ST_B]  = es;
    if (!flag_q) begin
      status_out[ST_C0] = c0;
      status_out[ST_C1] = 1'b0;
      status_out[ST_C2] = c2;
      status_out[ST_C3] = c3;
    end
  end

  assign flag_zf = c3;
  assign flag_pf = c2;
  assign flag_cf = c0;
  assign done    = done_q;

  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  assert_done_only_after_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));
  assert_unsup_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && any_unsup) |-> (flag_zf && flag_pf && flag_cf
                             && status_out[ST_IE] && !status_out[ST_DE]));
  assert_nan_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && any_nan && !any_unsup) |-> (flag_zf && flag_pf && flag_cf
                                         && !status_out[ST_DE]));
  assert_quiet_nan_no_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && quiet_q && any_nan && !any_snan && !any_unsup) |-> !status_out[ST_IE]);
  assert_summary_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status_out[ST_ES] == status_out[ST_B]));
  assert_single_relation_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_pf) |-> !(flag_zf && flag_cf));
  assert_flag_keep_cc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_q) |-> (status_out[ST_C3] == st_q[ST_C3] && status_out[ST_C2] == st_q[ST_C2]
                          && status_out[ST_C1] == st_q[ST_C1] && status_out[ST_C0] == st_q[ST_C0]));
  assert_flag_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_q) |-> (flag_zf == status_out[ST_C3] && flag_pf == status_out[ST_C2]
                           && flag_cf == status_out[ST_C0] && !status_out[ST_C1]));

endmodule

// File: tb/xfp_compare_unit_tb.sv
module xfp_compare_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [79:0] op_a = '0, op_b = '0;
  logic        quiet_mode = 1'b0, flag_mode = 1'b0, inv_mask = 1'b1, den_mask = 1'b1;
  logic [15:0] status_in = '0;
  logic        done, flag_zf, flag_pf, flag_cf;
  logic [15:0] status_out;

  xfp_compare_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .quiet_mode(quiet_mode), .flag_mode(flag_mode), .inv_mask(inv_mask),
    .den_mask(den_mask), .status_in(status_in), .done(done),
    .status_out(status_out), .flag_zf(flag_zf), .flag_pf(flag_pf), .flag_cf(flag_cf)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] st;
    logic [2:0]  fl;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  localparam logic [63:0] JBIT = 64'h8000_0000_0000_0000;

  function automatic logic [79:0] mk(bit s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  // 0 zero, 1 normal, 2 denormal, 3 pseudo-denormal, 4 inf, 5 qnan, 6 snan, 7 unsupported
  function automatic int kind_of(logic [14:0] e, logic [63:0] m);
    if (e == 15'h7FFF) begin
      if (m[63] == 1'b0) return 7;
      if (m[62:0] == 63'd0) return 4;
      return m[62] ? 5 : 6;
    end
    if (e == 15'd0) begin
      if (m == 64'd0) return 0;
      return m[63] ? 3 : 2;
    end
    return m[63] ? 1 : 7;
  endfunction

  // returns {c3, c2, c0, ie, de, es}
  function automatic logic [5:0] model(logic [79:0] a, logic [79:0] b, bit qm, bit im, bit dm);
    int ka, kb, ea, eb;
    logic [63:0] ma, mb;
    bit sa, sb_, za, zb, eq, lt, mlt, ie, de;
    ka = kind_of(a[78:64], a[63:0]);
    kb = kind_of(b[78:64], b[63:0]);
    if (ka == 7 || kb == 7) return {3'b111, 1'b1, 1'b0, !im};
    if (ka == 5 || ka == 6 || kb == 5 || kb == 6) begin
      ie = !qm || ka == 6 || kb == 6;
      return {3'b111, ie, 1'b0, ie && !im};
    end
    sa = a[79]; sb_ = b[79];
    ea = int'(a[78:64]); eb = int'(b[78:64]);
    ma = a[63:0]; mb = b[63:0];
    de = (ka == 2 || ka == 3 || kb == 2 || kb == 3);
    if (ka == 2 || ka == 3) begin ea = 1; while (!ma[63]) begin ma = ma << 1; ea--; end end
    if (kb == 2 || kb == 3) begin eb = 1; while (!mb[63]) begin mb = mb << 1; eb--; end end
    za = (ka == 0); zb = (kb == 0);
    eq = (za && zb) || (sa == sb_ && ea == eb && ma == mb);
    if (za)      mlt = !zb;
    else if (zb) mlt = 1'b0;
    else         mlt = (ea < eb) || (ea == eb && ma < mb);
    if (eq)              lt = 1'b0;
    else if (sa != sb_)  lt = sa;
    else                 lt = sa ? !mlt : mlt;
    return {eq, 1'b0, lt, 1'b0, de, de && !dm};
  endfunction

  task automatic send(logic [79:0] a, logic [79:0] b, bit qm, bit fm, bit im, bit dm,
                      logic [15:0] sin, string tag);
    logic [5:0] r;
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; quiet_mode = qm; flag_mode = fm;
    inv_mask = im; den_mask = dm; status_in = sin; in_valid = 1'b1;
    r = model(a, b, qm, im, dm);
    e.st = sin;
    e.st[0] = r[2]; e.st[1] = r[1]; e.st[7] = r[0]; e.st[15] = r[0];
    if (!fm) begin e.st[8] = r[3]; e.st[9] = 1'b0; e.st[10] = r[4]; e.st[14] = r[5]; end
    e.fl = r[5:3];
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: results are popped in order and compared away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R1: done without request, got done=1 exp done=0");
      end else begin
        cur = sb.pop_front();
        if (status_out !== cur.st || {flag_zf, flag_pf, flag_cf} !== cur.fl) begin
          errors++;
          $display("FAIL %s: status got %h exp %h, flags zf/pf/cf got %b exp %b",
                   cur.tag, status_out, cur.st, {flag_zf, flag_pf, flag_cf}, cur.fl);
        end
      end
    end
  end

  function automatic logic [79:0] rnd_op();
    logic [14:0] e;
    logic [63:0] m;
    case ($urandom_range(0, 7))
      0: e = 15'h0000;
      1: e = 15'h0001;
      2: e = 15'h7FFF;
      3: e = 15'h3FFF;
      4: e = 15'h3FFE;
      default: e = 15'($urandom_range(0, 32767));
    endcase
    case ($urandom_range(0, 5))
      0: m = 64'd0;
      1: m = JBIT;
      2: m = 64'd1 << $urandom_range(0, 63);
      3: m = {$urandom(), $urandom()} | JBIT;
      4: m = {$urandom(), $urandom()} >> $urandom_range(0, 63);
      default: m = {$urandom(), $urandom()};
    endcase
    return {1'($urandom_range(0, 1)), e, m};
  endfunction

  localparam logic [14:0] BIAS = 15'h3FFF;

  initial begin
    logic [79:0] one_p, one_n, two_p, two_n, zro_p, zro_n, qnan, snan, unn, pinf;
    one_p = mk(0, BIAS, JBIT);       one_n = mk(1, BIAS, JBIT);
    two_p = mk(0, BIAS + 1, JBIT);   two_n = mk(1, BIAS + 1, JBIT);
    zro_p = mk(0, 0, 0);             zro_n = mk(1, 0, 0);
    qnan  = mk(0, 15'h7FFF, 64'hC000_0000_0000_0000);
    snan  = mk(0, 15'h7FFF, 64'h8000_0000_0000_0001);
    unn   = mk(0, BIAS, 64'h4000_0000_0000_0000);
    pinf  = mk(0, 15'h7FFF, 64'd0);

    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0) begin errors++; $display("FAIL R1: reset done got %b exp 0", done); end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin errors++; $display("FAIL R1: idle done got %b exp 0", done); end

    send(one_p, two_p, 0, 0, 1, 1, 16'h0000, "R11 1<2");
    checks++;
    if (done !== 1'b1) begin errors++; $display("FAIL R1: done got %b exp 1", done); end
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin errors++; $display("FAIL R1: done width got %b exp 0", done); end

    send(two_p, one_p, 0, 0, 1, 1, 16'h3A7C, "R11 greater R13 passthru");
    send(two_n, one_n, 0, 0, 1, 1, 16'h0200, "R11 -2<-1");
    send(one_n, two_n, 0, 0, 1, 1, 16'h0000, "R11 -1>-2");
    send(mk(0, BIAS, 64'hC000_0000_0000_0000), mk(0, BIAS, 64'hC000_0000_0000_0000),
         0, 0, 1, 1, 16'h0000, "R8 equal");
    send(zro_p, zro_n, 0, 0, 1, 1, 16'h0000, "R8 +0==-0");
    send(one_n, one_p, 0, 0, 1, 1, 16'h0000, "R9 neg<pos");
    send(one_p, one_n, 0, 0, 1, 1, 16'h0000, "R9 pos>neg");
    send(zro_p, one_p, 0, 0, 1, 1, 16'h0000, "R10 +0<+1");
    send(zro_n, one_n, 0, 0, 1, 1, 16'h0000, "R10 -0>-1");
    send(one_p, zro_p, 0, 0, 1, 1, 16'h0000, "R10 +1>+0");
    send(one_n, zro_n, 0, 0, 1, 1, 16'h0000, "R10 -1<-0");
    send(unn, one_p, 0, 0, 0, 1, 16'h0000, "R2 unnormal unmasked");
    send(one_p, pinf, 0, 0, 1, 1, 16'h0000, "R2 pseudo-inf masked");
    send(unn, mk(0, 0, 64'd5), 0, 0, 1, 0, 16'h0000, "R2 unsupported beats denormal");
    send(qnan, one_p, 0, 0, 1, 1, 16'h0000, "R3 R4 qnan signalling masked");
    send(one_p, qnan, 0, 0, 0, 1, 16'h0000, "R4 qnan signalling unmasked");
    send(qnan, one_p, 1, 0, 0, 1, 16'h0000, "R4 qnan quiet");
    send(one_p, snan, 1, 0, 0, 1, 16'h0000, "R4 snan quiet");
    send(qnan, mk(0, 0, 64'd3), 1, 0, 1, 0, 16'h0000, "R3 nan beats denormal");
    send(mk(0, 0, 64'd1), mk(0, 0, 64'd2), 0, 0, 1, 0, 16'h0000, "R5 R7 denorm order unmasked");
    send(mk(1, 0, 64'd1), mk(1, 0, 64'd2), 0, 0, 1, 1, 16'h0000, "R5 R7 neg denorm masked");
    send(mk(0, 0, 64'h7FFF_FFFF_FFFF_FFFF), mk(0, 1, JBIT), 0, 0, 1, 1, 16'h0000, "R5 denorm<min normal");
    send(mk(0, 0, JBIT), mk(0, 1, JBIT), 0, 0, 1, 0, 16'h0000, "R6 pseudo-denorm == exp1");
    send(mk(0, 0, 64'hC000_0000_0000_0000), mk(0, 1, JBIT), 0, 0, 1, 1, 16'h0000, "R6 pseudo-denorm >");
    send(pinf | 80'h0_0000_8000_0000_0000_0000, two_p, 0, 0, 1, 1, 16'h0000, "R11 inf>2");
    send(one_p, two_p, 0, 1, 1, 1, 16'h4200, "R12 flag mode lt");
    send(one_p, one_p, 0, 1, 1, 1, 16'h0100, "R12 flag mode eq");
    send(qnan, one_p, 1, 1, 1, 1, 16'h0700, "R12 flag mode unordered");

    for (int i = 0; i < 400; i++)
      send(rnd_op(), rnd_op(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           16'($urandom()), "R13 random mix");

    @(negedge clk);
    @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1: pending results got %0d exp 0", sb.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1: watchdog expired, got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule